// File: doc/BRIEF.md
# Multi-Pattern Bit Error Rate Tester

This block is the traffic source and the error meter for a high-speed serial lane. It sits on the parallel word bus of a serial transceiver. On the transmit side a generator produces `W` bits per clock of one of three test patterns: a programmable word sent over and over, a maximal-length sequence of period 2^11−1, or one of period 2^31−1. On the receive side a checker takes the returning words. It locks onto the incoming sequence by itself, compares each word with a locally regenerated reference, and accumulates the number of wrong bits and the number of bits compared.

Control inputs choose the pattern, supply the programmable word, start and stop the generator, zero both counters and flip a single bit of one outgoing word. A test therefore proves that the measurement chain works before any real errors are counted. Every pattern step is unrolled so that a full bus word is made or checked in each clock. This lets the block keep up with the transceiver at its fastest line rate. The bus width `W` must be at least 31, so that one received word holds enough history to seed either sequence.

Top module: `bert_top`

## Requirements
- R1: After reset `tx_valid` and `rx_locked` are 0 and both counters read 0.
- R2: With `pat_sel`=1 the generator emits the sequence a(n)=a(n−11)⊕a(n−9), with the earliest bit in bit 0 of each word. A `ctl_start` pulse loads a state of all ones and makes `tx_valid` high with the first word on the next clock.
- R3: With `pat_sel`=2 the generator emits the sequence a(n)=a(n−31)⊕a(n−28), with the same bit order and the same all-ones start state.
- R4: With `pat_sel`=0 every emitted word equals `user_word`.
- R5: The shift state of the generator is never all-zero while it runs a sequence pattern. Each `ctl_start` restarts the sequence from the all-ones state. The pattern is latched at `ctl_start`.
- R6: While hunting, the checker reseeds its reference from each received word. It enters lock after `LOCK_RUN` consecutive error-free valid words that follow a seeding word. In word mode no seeding word is needed.
- R7: A locked checker drops to hunting after a valid word with more than `LOSS_THR` bit errors. A word with exactly `LOSS_THR` errors keeps the lock.
- R8: For each valid word processed while locked, the error counter adds the popcount of the received word XOR the expected word. The counter saturates at all ones.
- R9: The bit counter adds `W` for each valid word processed while locked and saturates at all ones. Neither counter moves while the checker hunts.
- R10: `ctl_clear` sets both counters to 0 on the next clock and takes priority over any increment.
- R11: `ctl_inject` while the generator runs flips bit 0 of the word registered on that clock. A locked checker then counts exactly one error.
- R12: `ctl_stop` drops `tx_valid` on the next clock (`ctl_start` wins if both are high). Words with `rx_valid` low change neither the lock nor the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_start | input | 1 | Pulse: reseed and start generating |
| ctl_stop | input | 1 | Pulse: stop generating |
| ctl_clear | input | 1 | Pulse: zero both counters |
| ctl_inject | input | 1 | Pulse: flip bit 0 of the next word |
| pat_sel | input | 2 | 0 word, 1 short sequence, 2 long sequence |
| user_word | input | W | Programmable pattern word |
| tx_data | output | W | Generated word |
| tx_valid | output | 1 | Generated word is valid |
| rx_data | input | W | Returning word |
| rx_valid | input | 1 | Returning word is valid |
| rx_locked | output | 1 | Checker is locked |
| err_count | output | CNT_W | Saturating bit-error count |
| bit_count | output | CNT_W | Saturating compared-bit count |

## Verification
The assertions check several rules on every cycle. Start must lead to a valid word, and stop must lead to silence. The running sequence state must never be zero. The error counter must never decrease except on clear, and clear must zero both counters. A locked valid word must add exactly `W` to the bit count, and nothing may be counted while the checker hunts. Other behaviour only the bench scenarios can show: that the words follow the two recurrences bit for bit, the exact number of words needed to relock, the exact error totals from injected and masked faults, the loss threshold edge and saturation of the counters.

// File: rtl/bert_pkg.sv
package bert_pkg;

    typedef enum logic [1:0] {
        PAT_WORD   = 2'd0,
        PAT_PRBS11 = 2'd1,
        PAT_PRBS31 = 2'd2
    } pat_e;

    typedef enum logic {
        CHK_HUNT = 1'b0,
        CHK_LOCK = 1'b1
    } chk_state_e;

    localparam int            LFSR_W    = 31;
    localparam logic [30:0]   LFSR_SEED = '1;

    // Feedback bit for one serial step of the selected recurrence.
    function automatic logic fb_bit(input pat_e p, input logic [LFSR_W-1:0] s);
        if (p == PAT_PRBS11) return s[10] ^ s[8];
        return s[30] ^ s[27];
    endfunction

endpackage

// File: rtl/bert_prbs_step.sv
module bert_prbs_step
    import bert_pkg::*;
#(
    parameter int W = 32
) (
    input  pat_e              pat,
    input  logic [LFSR_W-1:0] state_i,
    output logic [W-1:0]      word_o,
    output logic [LFSR_W-1:0] state_o
);
    // W serial steps unrolled; earliest bit lands in bit 0.
    always_comb begin
        logic [LFSR_W-1:0] s;
        logic              nb;
        s      = state_i;
        word_o = '0;
        for (int i = 0; i < W; i++) begin
            nb        = fb_bit(pat, s);
            word_o[i] = nb;
            s         = {s[LFSR_W-2:0], nb};
        end
        state_o = s;
    end
endmodule

// File: rtl/bert_sat_acc.sv
module bert_sat_acc #(
    parameter int CNT_W = 48,
    parameter int INC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W:0] sum;

    always_comb sum = {1'b0, cnt} + (CNT_W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (en)     cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
endmodule

// File: rtl/bert_gen.sv
module bert_gen
    import bert_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              inject,
    input  pat_e              pat_i,
    input  logic [W-1:0]      user_word,
    output logic [W-1:0]      tx_data,
    output logic              tx_valid,
    output logic [LFSR_W-1:0] state_o,
    output pat_e              pat_o
);
    logic              running;
    logic [LFSR_W-1:0] lfsr_q;
    pat_e              pat_q;
    pat_e              use_pat;
    logic [LFSR_W-1:0] cur_state;
    logic [LFSR_W-1:0] nxt_state;
    logic [W-1:0]      seq_word;
    logic [W-1:0]      base_word;

    always_comb begin
        use_pat   = start ? pat_i : pat_q;
        cur_state = start ? LFSR_SEED : lfsr_q;
        base_word = (use_pat == PAT_WORD) ? user_word : seq_word;
    end

    bert_prbs_step #(.W(W)) u_step (
        .pat     (use_pat),
        .state_i (cur_state),
        .word_o  (seq_word),
        .state_o (nxt_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            lfsr_q   <= LFSR_SEED;
            pat_q    <= PAT_PRBS11;
            tx_data  <= '0;
            tx_valid <= 1'b0;
        end else if (start || (running && !stop)) begin
            running  <= 1'b1;
            lfsr_q   <= nxt_state;
            if (start) pat_q <= pat_i;
            tx_data  <= base_word ^ W'(inject);
            tx_valid <= 1'b1;
        end else begin
            running  <= 1'b0;
            tx_valid <= 1'b0;
        end
    end

    assign state_o = lfsr_q;
    assign pat_o   = pat_q;
endmodule

// File: rtl/bert_chk.sv
module bert_chk
    import bert_pkg::*;
#(
    parameter int W        = 32,
    parameter int CNT_W    = 48,
    parameter int LOCK_RUN = 4,
    parameter int LOSS_THR = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pat_e             pat,
    input  logic [W-1:0]     user_word,
    input  logic [W-1:0]     rx_data,
    input  logic             rx_valid,
    input  logic             clear,
    output logic             locked,
    output logic [CNT_W-1:0] err_cnt,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam int EW    = $clog2(W + 1);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);

    chk_state_e        st;
    logic              seeded;
    logic [RUN_W-1:0]  run;
    logic [LFSR_W-1:0] ref_q;
    logic [LFSR_W-1:0] ref_nxt;
    logic [LFSR_W-1:0] seed_w;
    logic [W-1:0]      seq_word;
    logic [W-1:0]      exp_word;
    logic [W-1:0]      diff;
    logic [EW-1:0]     errs;
    logic              count_en;

    bert_prbs_step #(.W(W)) u_ref (
        .pat     (pat),
        .state_i (ref_q),
        .word_o  (seq_word),
        .state_o (ref_nxt)
    );

    // Newest received bit is the most recent history bit of the recurrence.
    always_comb begin
        for (int j = 0; j < LFSR_W; j++) seed_w[j] = rx_data[W-1-j];
        exp_word = (pat == PAT_WORD) ? user_word : seq_word;
        diff     = rx_data ^ exp_word;
        errs     = '0;
        for (int i = 0; i < W; i++) errs = errs + EW'(diff[i]);
        count_en = rx_valid && (st == CHK_LOCK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= CHK_HUNT;
            seeded <= 1'b0;
            run    <= '0;
            ref_q  <= LFSR_SEED;
        end else if (rx_valid) begin
            case (st)
                CHK_HUNT: begin
                    ref_q  <= seed_w;
                    seeded <= 1'b1;
                    if ((seeded || pat == PAT_WORD) && errs == '0) begin
                        if (run == RUN_W'(LOCK_RUN - 1)) begin
                            st  <= CHK_LOCK;
                            run <= '0;
                        end else begin
                            run <= run + 1'b1;
                        end
                    end else begin
                        run <= '0;
                    end
                end
                default: begin
                    ref_q <= ref_nxt;
                    if (int'(errs) > LOSS_THR) begin
                        st     <= CHK_HUNT;
                        seeded <= 1'b0;
                        run    <= '0;
                    end
                end
            endcase
        end
    end

    bert_sat_acc #(.CNT_W(CNT_W), .INC_W(EW)) u_err_acc (
        .clk (clk),
        .rst (rst),
        .clr (clear),
        .en  (count_en),
        .inc (errs),
        .cnt (err_cnt)
    );

    bert_sat_acc #(.CNT_W(CNT_W), .INC_W(EW)) u_bit_acc (
        .clk (clk),
        .rst (rst),
        .clr (clear),
        .en  (count_en),
        .inc (EW'(W)),
        .cnt (bit_cnt)
    );

    assign locked = (st == CHK_LOCK);
endmodule

// File: rtl/bert_top.sv
module bert_top
    import bert_pkg::*;
#(
    parameter int W        = 32,
    parameter int CNT_W    = 48,
    parameter int LOCK_RUN = 4,
    parameter int LOSS_THR = W / 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_start,
    input  logic             ctl_stop,
    input  logic             ctl_clear,
    input  logic             ctl_inject,
    input  logic [1:0]       pat_sel,
    input  logic [W-1:0]     user_word,
    output logic [W-1:0]     tx_data,
    output logic             tx_valid,
    input  logic [W-1:0]     rx_data,
    input  logic             rx_valid,
    output logic             rx_locked,
    output logic [CNT_W-1:0] err_count,
    output logic [CNT_W-1:0] bit_count
);
    pat_e              pat;
    pat_e              gen_pat;
    logic [LFSR_W-1:0] gen_state;

    assign pat = pat_e'(pat_sel);

    bert_gen #(.W(W)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .start     (ctl_start),
        .stop      (ctl_stop),
        .inject    (ctl_inject),
        .pat_i     (pat),
        .user_word (user_word),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .state_o   (gen_state),
        .pat_o     (gen_pat)
    );

    bert_chk #(
        .W(W), .CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN), .LOSS_THR(LOSS_THR)
    ) u_chk (
        .clk       (clk),
        .rst       (rst),
        .pat       (pat),
        .user_word (user_word),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .clear     (ctl_clear),
        .locked    (rx_locked),
        .err_cnt   (err_count),
        .bit_cnt   (bit_count)
    );
endmodule

// File: rtl/bert_sva.sv
module bert_sva #(
    parameter int W     = 32,
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_start,
    input logic             ctl_stop,
    input logic             ctl_clear,
    input logic             tx_valid,
    input logic             rx_valid,
    input logic             rx_locked,
    input logic [CNT_W-1:0] err_count,
    input logic [CNT_W-1:0] bit_count,
    input logic [30:0]      gen_state,
    input logic [1:0]       gen_pat
);
    localparam logic [CNT_W-1:0] ALL1 = '1;
    localparam logic [CNT_W-1:0] LIM  = ALL1 - CNT_W'(W);

    p_start_valid_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_start |=> tx_valid);

    p_stop_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (ctl_stop && !ctl_start) |=> !tx_valid);

    p_short_state_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && gen_pat == 2'd1) |-> (gen_state[10:0] != '0));

    p_long_state_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && gen_pat[1]) |-> (gen_state != '0));

    p_err_monotonic_r8: assert property (@(posedge clk) disable iff (rst)
        !ctl_clear |=> (err_count >= $past(err_count)));

    p_bit_step_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_locked && !ctl_clear && bit_count <= LIM)
        |=> (bit_count == $past(bit_count) + CNT_W'(W)));

    p_hunt_no_count_r9: assert property (@(posedge clk) disable iff (rst)
        ((!rx_locked || !rx_valid) && !ctl_clear)
        |=> ($stable(bit_count) && $stable(err_count)));

    p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_clear |=> (err_count == '0 && bit_count == '0));
endmodule

bind bert_top bert_sva #(.W(W), .CNT_W(CNT_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .ctl_start (ctl_start),
    .ctl_stop  (ctl_stop),
    .ctl_clear (ctl_clear),
    .tx_valid  (tx_valid),
    .rx_valid  (rx_valid),
    .rx_locked (rx_locked),
    .err_count (err_count),
    .bit_count (bit_count),
    .gen_state (gen_state),
    .gen_pat   (gen_pat)
);

// File: tb/tb_bert_top.sv
`timescale 1ns/1ps
module tb_bert_top;
    localparam int W     = 32;
    localparam int CNT_W = 16;
    localparam int THR   = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ctl_start = 1'b0, ctl_stop = 1'b0, ctl_clear = 1'b0, ctl_inject = 1'b0;
    logic [1:0]       pat_sel = 2'd1;
    logic [W-1:0]     user_word = '0;
    logic [W-1:0]     tx_data, rx_data;
    logic             tx_valid, rx_valid, rx_locked;
    logic [CNT_W-1:0] err_count, bit_count;
    logic [W-1:0]     err_mask = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    assign rx_data  = tx_data ^ err_mask;
    assign rx_valid = tx_valid;

    bert_top #(.W(W), .CNT_W(CNT_W), .LOCK_RUN(4), .LOSS_THR(THR)) dut (
        .clk(clk), .rst(rst), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
        .ctl_clear(ctl_clear), .ctl_inject(ctl_inject), .pat_sel(pat_sel),
        .user_word(user_word), .tx_data(tx_data), .tx_valid(tx_valid),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_locked(rx_locked),
        .err_count(err_count), .bit_count(bit_count)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        ctl_start = 1'b1; cyc(1); ctl_start = 1'b0;
    endtask

    task automatic do_clear();
        ctl_clear = 1'b1; cyc(1); ctl_clear = 1'b0;
    endtask

    task automatic wait_lock();
        for (int i = 0; i < 60 && !rx_locked; i++) cyc(1);
    endtask

    // Reference model of the serial recurrences, earliest bit in bit 0.
    function automatic logic [W-1:0] mword(inout logic [30:0] s, input int len);
        logic [W-1:0] w;
        logic nb;
        for (int i = 0; i < W; i++) begin
            nb   = (len == 11) ? (s[10] ^ s[8]) : (s[30] ^ s[27]);
            w[i] = nb;
            s    = {s[29:0], nb};
        end
        return w;
    endfunction

    function automatic logic [W-1:0] rmask(input int k);
        logic [W-1:0] m = '0;
        while ($countones(m) < k) m[$urandom_range(W-1, 0)] = 1'b1;
        return m;
    endfunction

    initial begin
        logic [30:0] ms;
        logic [W-1:0] first_word;
        longint exp_err;
        longint b0;
        int bad;
        void'($urandom(32'd1234));

        cyc(3); rst = 1'b0; cyc(1);
        check("R1 tx_valid", tx_valid, 0);
        check("R1 locked", rx_locked, 0);
        check("R1 err_count", err_count, 0);
        check("R1 bit_count", bit_count, 0);

        // Short sequence
        pat_sel = 2'd1;
        pulse_start();
        check("R2 valid after start", tx_valid, 1);
        ms = '1; bad = 0; first_word = tx_data;
        for (int k = 0; k < 40; k++) begin
            if (tx_data !== mword(ms, 11)) bad++;
            cyc(1);
        end
        check("R2 short sequence words", bad, 0);
        wait_lock();
        check("R6 initial lock", rx_locked, 1);

        do_clear();
        check("R10 err cleared", err_count, 0);
        check("R10 bits cleared", bit_count, 0);
        cyc(50);
        check("R9 bits over 50 words", bit_count, 50 * W);
        check("R8 no errors clean link", err_count, 0);

        ctl_inject = 1'b1; cyc(1); ctl_inject = 1'b0; cyc(1);
        check("R11 one injected error", err_count, 1);
        check("R11 still locked", rx_locked, 1);

        // Random masked errors within the threshold
        do_clear();
        exp_err = 0;
        for (int k = 0; k < 30; k++) begin
            int nb = $urandom_range(THR, 1);
            err_mask = rmask(nb); cyc(1); err_mask = '0;
            exp_err += nb;
            cyc($urandom_range(3, 0));
        end
        check("R8 random error total", err_count, exp_err);
        check("R7 lock kept under threshold", rx_locked, 1);

        err_mask = rmask(THR); cyc(1); err_mask = '0;
        check("R7 exactly threshold keeps lock", rx_locked, 1);

        do_clear();
        err_mask = rmask(THR + 1); cyc(1); err_mask = '0;
        check("R7 lock lost above threshold", rx_locked, 0);
        check("R8 loss word counted", err_count, THR + 1);
        b0 = bit_count;
        cyc(4);
        check("R6 still hunting after 4 words", rx_locked, 0);
        check("R9 no bits while hunting", bit_count, b0);
        cyc(1);
        check("R6 relock after 5 words", rx_locked, 1);

        // Stop; garbage with rx_valid low is ignored
        ctl_stop = 1'b1; cyc(1); ctl_stop = 1'b0;
        check("R12 valid drops", tx_valid, 0);
        b0 = bit_count; exp_err = err_count;
        err_mask = 32'hFFFF_FFFF; cyc(5); err_mask = '0;
        check("R12 bits held when idle", bit_count, b0);
        check("R12 errors held when idle", err_count, exp_err);
        check("R12 lock held when idle", rx_locked, 1);

        // Restart short sequence reseeds
        pulse_start();
        check("R5 restart reseeds", tx_data, first_word);

        // Long sequence
        pat_sel = 2'd2;
        pulse_start();
        ms = '1; bad = 0;
        for (int k = 0; k < 40; k++) begin
            if (tx_data !== mword(ms, 31)) bad++;
            if (tx_data == '0) bad++;
            cyc(1);
        end
        check("R3 long sequence words", bad, 0);
        wait_lock();
        check("R6 lock on long sequence", rx_locked, 1);

        // Programmable word
        pat_sel = 2'd0; user_word = $urandom();
        pulse_start();
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            if (tx_data !== user_word) bad++;
            cyc(1);
        end
        check("R4 user word repeated", bad, 0);
        wait_lock();
        check("R6 lock on user word", rx_locked, 1);

        // Saturation with THR errors per word
        do_clear();
        err_mask = 32'h0000_00FF;
        cyc(8300);
        err_mask = '0;
        check("R8 err saturates", err_count, 16'hFFFF);
        check("R9 bits saturate", bit_count, 16'hFFFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule